// File: doc/BRIEF.md
# Stepped Power-Down Output Divider

This block turns a fast synthesizer clock into the output clock. A 2-bit code selects the base ratio. A power-down request raises that ratio by a factor of sixteen. The factor is applied as four doublings, each triggered by a rising edge of the slower reference clock, so the output frequency moves in gentle steps. When the request is withdrawn, the ratio returns to the coded value through the same four halvings in reverse.

The fast clock port `vco2x_clk` runs at twice the VCO frequency, so one cycle is one VCO half-period. A ratio of R therefore gives an output that is high for R cycles and low for R cycles, which keeps a 50% duty cycle even at R = 1. All changes of ratio (from a step or from a new code) and all changes of the output enable wait for a period boundary. A period boundary is the cycle in which the output is about to rise, so the block never produces a shortened pulse.

The reference clock, the power-down request and the enable are passed through a synchronizer before use. The power-down sequencer has four states:
- RUN: level 0.
- SLOWING: stepping up.
- PARKED: level at its maximum.
- RESUMING: stepping down.

Its transitions are taken only on a reference tick:
- RUN→SLOWING/PARKED when the request is seen.
- SLOWING→PARKED on reaching the top level.
- PARKED→RESUMING when the request drops.
- RESUMING→RUN on reaching level 0.
- SLOWING↔RESUMING when the request reverses mid-sequence.

The divider phase machine alternates between LOW and HIGH. Its LOW→HIGH transition is the period boundary.

Top module: `postdiv_pd`

## Requirements
- R1: With no power-down, code 2'b00 gives ratio 2, 2'b01 ratio 4, 2'b10 ratio 8 and 2'b11 ratio 1; the output is high for R and low for R cycles of `vco2x_clk`.
- R2: In every period, the high time equals the following low time.
- R3: With power-down fully applied, codes 00, 01, 10 and 11 give ratios 32, 64, 128 and 16.
- R4: Asserting power-down raises the ratio one doubling per synchronized reference rising edge, passing through every intermediate ratio, four steps in all.
- R5: Deasserting power-down halves the ratio once per synchronized reference rising edge until the coded ratio is reached.
- R6: A new ratio (from a code change or a step) takes effect only at the next rising edge of the output; a pulse in progress and its low phase keep the old length.
- R7: With the enable low, the output stays low. Enable changes take effect only at a rising boundary, so every high pulse has full length.
- R8: During reset, the output is low and the sequencer is at level 0.
- R9: If the request reverses during a sequence, stepping turns around from the current level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco2x_clk | input | 1 | Fast clock at twice the VCO rate |
| ref_clk | input | 1 | Reference clock that paces power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_code | input | 2 | Base divide code |
| pd_req | input | 1 | Power-down request, active high |
| out_en | input | 1 | Output enable, active high |
| fout | output | 1 | Divided output clock |

## Verification
The bench uses the defaults, PD_STEPS = 4 and SYNC_STAGES = 2, with the reference toggling every 40 fast cycles. This setting reaches all eight ratios, including the 128 ratio that exercises the full counter width and the top level of the sequencer. Each reference level lasts longer than the longest output period seen during the ramps, so every intermediate doubling and halving shows up as its own pulse width. A request withdrawn after two or three ticks reaches the reversal path from the middle of the ramp.

// File: rtl/ps_pkg.sv
package ps_pkg;

    typedef enum logic [1:0] {
        PD_RUN,
        PD_SLOWING,
        PD_PARKED,
        PD_RESUMING
    } pd_state_e;

    typedef enum logic {
        PH_LOW,
        PH_HIGH
    } phase_e;

    // log2 of the base ratio selected by the 2-bit code
    function automatic logic [1:0] code_base(input logic [1:0] code);
        logic [1:0] e;
        unique case (code)
            2'b00: e = 2'd1;
            2'b01: e = 2'd2;
            2'b10: e = 2'd3;
            2'b11: e = 2'd0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ps_pd_seq.sv
module ps_pd_seq
    import ps_pkg::*;
#(
    parameter int PD_STEPS = 4,
    parameter int LVL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_s,
    input  logic             pd_s,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(PD_STEPS);

    pd_state_e        state_q, state_d;
    logic [LVL_W-1:0] level_q, level_d;
    logic             ref_d;
    logic             tick;
    logic [LVL_W-1:0] up, dn;

    assign tick = ref_s & ~ref_d;
    assign up   = level_q + LVL_W'(1);
    assign dn   = level_q - LVL_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_RUN;
            level_q <= '0;
            ref_d   <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            ref_d   <= ref_s;
        end
    end

    // next state: moves only on a reference tick
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        if (tick) begin
            unique case (state_q)
                PD_RUN: begin
                    if (pd_s) begin
                        level_d = up;
                        state_d = (up == TOP_LVL) ? PD_PARKED : PD_SLOWING;
                    end
                end
                PD_SLOWING, PD_RESUMING: begin
                    if (pd_s) begin
                        level_d = up;
                        state_d = (up == TOP_LVL) ? PD_PARKED : PD_SLOWING;
                    end else begin
                        level_d = dn;
                        state_d = (dn == '0) ? PD_RUN : PD_RESUMING;
                    end
                end
                PD_PARKED: begin
                    if (!pd_s) begin
                        level_d = dn;
                        state_d = (dn == '0) ? PD_RUN : PD_RESUMING;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        level = level_q;
    end

    a_r3_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= TOP_LVL);

    a_r4_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> $past(tick));

    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && $past(pd_s) && ($past(level_q) != TOP_LVL))
        |-> (level_q == $past(level_q) + LVL_W'(1)));

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && !$past(pd_s) && ($past(level_q) != '0))
        |-> (level_q == $past(level_q) - LVL_W'(1)));

    a_r9_state_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_RUN) |-> (level_q == '0));
endmodule

// File: rtl/ps_divider.sv
module ps_divider
    import ps_pkg::*;
#(
    parameter int MAX_E = 7,
    parameter int E_W   = 3,
    parameter int CNT_W = 7,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       n_code,
    input  logic [LVL_W-1:0] level,
    input  logic             oe_s,
    output logic             fout
);
    localparam logic [E_W-1:0] MAX_EV = E_W'(MAX_E);

    function automatic logic [CNT_W-1:0] half_len(input logic [E_W-1:0] e);
        return {CNT_W{1'b1}} >> (MAX_EV - e);
    endfunction

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [E_W-1:0]   e_cur, e_d, e_tgt;
    logic             oe_cur, oe_d;
    logic             fout_q, fout_d;
    logic             boundary;

    assign e_tgt    = E_W'(code_base(n_code)) + E_W'(level);
    assign boundary = (cnt_q == '0) && (phase_q == PH_LOW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            e_cur   <= '0;
            oe_cur  <= 1'b0;
            fout_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            e_cur   <= e_d;
            oe_cur  <= oe_d;
            fout_q  <= fout_d;
        end
    end

    // next state: LOW->HIGH is the only place ratio and enable change
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q - CNT_W'(1);
        e_d     = e_cur;
        oe_d    = oe_cur;
        if (cnt_q == '0) begin
            unique case (phase_q)
                PH_LOW: begin
                    phase_d = PH_HIGH;
                    e_d     = e_tgt;
                    oe_d    = oe_s;
                    cnt_d   = half_len(e_tgt);
                end
                PH_HIGH: begin
                    phase_d = PH_LOW;
                    cnt_d   = half_len(e_cur);
                end
            endcase
        end
        fout_d = (phase_d == PH_HIGH) && oe_d;
    end

    // outputs
    always_comb begin
        fout = fout_q;
    end

    a_r6_ratio_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (e_cur != $past(e_cur)) |-> $past(boundary));

    a_r7_enable_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_cur != $past(oe_cur)) |-> $past(boundary));

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= half_len(e_cur));

    a_r7_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fout_q)) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/postdiv_pd.sv
module postdiv_pd #(
    parameter int PD_STEPS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       vco2x_clk,
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic [1:0] n_code,
    input  logic       pd_req,
    input  logic       out_en,
    output logic       fout
);
    localparam int MAX_E = 3 + PD_STEPS;
    localparam int E_W   = $clog2(MAX_E + 1);
    localparam int CNT_W = MAX_E;
    localparam int LVL_W = $clog2(PD_STEPS + 1);

    logic [2:0]       raw_in, synced;
    logic [LVL_W-1:0] level;

    assign raw_in = {out_en, pd_req, ref_clk};

    ps_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk   (vco2x_clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    ps_pd_seq #(.PD_STEPS(PD_STEPS), .LVL_W(LVL_W)) u_seq (
        .clk   (vco2x_clk),
        .rst_n (rst_n),
        .ref_s (synced[0]),
        .pd_s  (synced[1]),
        .level (level)
    );

    ps_divider #(.MAX_E(MAX_E), .E_W(E_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_div (
        .clk    (vco2x_clk),
        .rst_n  (rst_n),
        .n_code (n_code),
        .level  (level),
        .oe_s   (synced[2]),
        .fout   (fout)
    );
endmodule

// File: tb/sim_postdiv_pd.sv
`timescale 1ns/1ps
module sim_postdiv_pd;
    localparam int PD_STEPS = 4;
    localparam int SYNC     = 2;
    localparam int REF_HALF = 40;

    logic       clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] n_code = 2'b11;
    logic       pd_req = 1'b0;
    logic       out_en = 1'b1;
    logic       fout;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R8";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    initial forever begin
        repeat (REF_HALF) @(negedge clk);
        ref_clk = ~ref_clk;
    end

    postdiv_pd #(.PD_STEPS(PD_STEPS), .SYNC_STAGES(SYNC)) u0 (
        .vco2x_clk (clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .n_code    (n_code),
        .pd_req    (pd_req),
        .out_en    (out_en),
        .fout      (fout)
    );

    // behavioural reference model
    bit ref_p[SYNC], pd_p[SYNC], oe_p[SYNC];
    bit m_refd, m_hi, m_oe, m_fout;
    int m_level, m_e, m_cnt;

    function automatic int base_of(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 2;
            2'b10: return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_p[i]) begin ref_p[i] = 0; pd_p[i] = 0; oe_p[i] = 0; end
            m_refd = 0; m_hi = 0; m_oe = 0; m_fout = 0;
            m_level = 0; m_e = 0; m_cnt = 0;
        end else begin
            bit rs, ps, os, tick;
            int nlev, etgt;
            rs = ref_p[SYNC-1]; ps = pd_p[SYNC-1]; os = oe_p[SYNC-1];
            tick = rs && !m_refd;
            nlev = m_level;
            if (tick) begin
                if (ps && m_level < PD_STEPS) nlev = m_level + 1;
                else if (!ps && m_level > 0) nlev = m_level - 1;
            end
            etgt = base_of(n_code) + m_level;
            if (m_cnt == 0) begin
                if (!m_hi) begin
                    m_e = etgt; m_oe = os; m_cnt = (1 << etgt) - 1; m_hi = 1;
                end else begin
                    m_cnt = (1 << m_e) - 1; m_hi = 0;
                end
            end else begin
                m_cnt = m_cnt - 1;
            end
            m_fout = m_hi && m_oe;
            m_level = nlev;
            m_refd = rs;
            for (int i = SYNC - 1; i > 0; i--) begin
                ref_p[i] = ref_p[i-1]; pd_p[i] = pd_p[i-1]; oe_p[i] = oe_p[i-1];
            end
            ref_p[0] = ref_clk; pd_p[0] = pd_req; oe_p[0] = out_en;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (fout !== m_fout) begin
                fails++;
                $display("FAIL %s: fout actual %0b expected %0b at %0t", cur_req, fout, m_fout, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic meas(output int hi, output int lo);
        hi = 0; lo = 0;
        @(negedge clk);
        while (fout !== 1'b0) @(negedge clk);
        while (fout !== 1'b1) @(negedge clk);
        while (fout === 1'b1) begin hi++; @(negedge clk); end
        while (fout === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic align_fall();
        @(negedge clk);
        while (fout !== 1'b1) @(negedge clk);
        while (fout === 1'b1) @(negedge clk);
    endtask

    task automatic collect(input int ncyc, ref int q[$]);
        int run = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (fout === 1'b1) run++;
            else if (run > 0) begin
                if (q.size() == 0 || q[$] != run) q.push_back(run);
                run = 0;
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: run actual hung expected done");
        finish_run();
    end

    initial begin
        int hi, lo;
        int codes[4] = '{3, 0, 1, 2};
        int base_r[4] = '{1, 2, 4, 8};
        int q[$];
        int exp_up[5] = '{1, 2, 4, 8, 16};
        int exp_dn[5] = '{16, 8, 4, 2, 1};
        int mx;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(fout === 1'b0, "R8", int'(fout), 0, "fout in reset");
        rst_n = 1'b1;

        // R1 / R2: base ratios
        foreach (codes[k]) begin
            cur_req = "R1";
            n_code = 2'(codes[k]);
            repeat (300) @(negedge clk);
            meas(hi, lo);
            chk(hi == base_r[k], "R1", hi, base_r[k], "high width");
            chk(lo == hi, "R2", lo, hi, "low width");
        end

        // R3: fully powered down ratios
        cur_req = "R3";
        pd_req = 1'b1;
        repeat (600) @(negedge clk);
        foreach (codes[k]) begin
            n_code = 2'(codes[k]);
            repeat (400) @(negedge clk);
            meas(hi, lo);
            chk(hi == 16 * base_r[k], "R3", hi, 16 * base_r[k], "high width");
            chk(lo == hi, "R2", lo, hi, "low width at pd");
        end

        // R5: release steps back down
        cur_req = "R5";
        n_code = 2'b11;
        repeat (400) @(negedge clk);
        align_fall();
        pd_req = 1'b0;
        q.delete();
        collect(700, q);
        chk(q.size() == 5, "R5", q.size(), 5, "number of widths");
        foreach (exp_dn[k]) if (k < q.size())
            chk(q[k] == exp_dn[k], "R5", q[k], exp_dn[k], "step width");

        // R4: assertion steps up
        cur_req = "R4";
        align_fall();
        pd_req = 1'b1;
        q.delete();
        collect(700, q);
        chk(q.size() == 5, "R4", q.size(), 5, "number of widths");
        foreach (exp_up[k]) if (k < q.size())
            chk(q[k] == exp_up[k], "R4", q[k], exp_up[k], "step width");

        // R9: reversal mid-sequence
        cur_req = "R9";
        pd_req = 1'b0;
        repeat (600) @(negedge clk);
        align_fall();
        q.delete();
        pd_req = 1'b1;
        fork
            collect(800, q);
            begin repeat (200) @(negedge clk); pd_req = 1'b0; end
        join
        mx = 0;
        foreach (q[k]) if (q[k] > mx) mx = q[k];
        chk(mx >= 2 && mx <= 8, "R9", mx, 8, "peak width");
        chk(q.size() > 0 && q[$] == 1, "R9", (q.size() > 0) ? q[$] : -1, 1, "final width");

        // R7: enable gating without runts
        cur_req = "R7";
        n_code = 2'b10;
        repeat (300) @(negedge clk);
        while (fout !== 1'b0) @(negedge clk);
        while (fout !== 1'b1) @(negedge clk);
        hi = 0;
        while (fout === 1'b1) begin
            hi++;
            if (hi == 3) out_en = 1'b0;
            @(negedge clk);
        end
        chk(hi == 8, "R7", hi, 8, "pulse width when disabled mid-pulse");
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (fout === 1'b1) hi++;
        end
        chk(hi == 0, "R7", hi, 0, "high cycles while disabled");
        out_en = 1'b1;
        meas(hi, lo);
        chk(hi == 8, "R7", hi, 8, "first pulse after enable");

        // R6: code change mid-pulse waits for boundary
        cur_req = "R6";
        while (fout !== 1'b0) @(negedge clk);
        while (fout !== 1'b1) @(negedge clk);
        hi = 0;
        while (fout === 1'b1) begin
            hi++;
            if (hi == 3) n_code = 2'b00;
            @(negedge clk);
        end
        lo = 0;
        while (fout === 1'b0) begin lo++; @(negedge clk); end
        chk(hi == 8, "R6", hi, 8, "pulse in progress");
        chk(lo == 8, "R6", lo, 8, "low phase after change");
        meas(hi, lo);
        chk(hi == 2, "R6", hi, 2, "new ratio width");

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule